// File: doc/BRIEF.md
# Modulo-4 Up/Down Counter with Count-Two Detection

This block is a two-bit synchronous counter built as a four-state machine. One direction input selects the count direction. When the input is low the count goes up by one on each rising clock edge. When it is high the count goes down by one. The count wraps at both ends, so 3 goes up to 0 and 0 goes down to 3.

A single detect output is a Mealy output. It depends on the present count and the direction input. It is high in the cycle before the edge that moves the count onto 2. This happens from 1 when counting up and from 3 when counting down. Logic downstream can therefore act on the arrival at 2 in the same cycle as the transition that reaches it. The state sits in two D flip-flops, and combinational logic forms the next state and the output. A synchronous active-low reset clears the count to 0.

Top module: `updn4_cnt_det`

## Requirements
- R1: When `rst_n` is low at a rising edge of `clk`, `cnt_o` is 0 after that edge. While `rst_n` is low, `hit_o` is 0.
- R2: With `rst_n` high and `dir_dn` = 0, each rising edge raises `cnt_o` by one (for example 0 to 1, 1 to 2, 2 to 3).
- R3: With `rst_n` high and `dir_dn` = 1, each rising edge lowers `cnt_o` by one (for example 3 to 2, 2 to 1, 1 to 0).
- R4: Counting up from 3 (`dir_dn` = 0) gives 0 at the next edge.
- R5: Counting down from 0 (`dir_dn` = 1) gives 3 at the next edge.
- R6: With `rst_n` high, `hit_o` is 1 when `cnt_o` = 1 and `dir_dn` = 0, and when `cnt_o` = 3 and `dir_dn` = 1.
- R7: In every other combination of `cnt_o`, `dir_dn` and `rst_n`, `hit_o` is 0. This includes the cycles in which the count already sits at 2.
- R8: `hit_o` is combinational from the present count and `dir_dn`, and is valid in the cycle before the edge. Whenever `hit_o` is 1 (with `rst_n` high) at an edge, `cnt_o` is 2 after that edge.
- R9: `cnt_o` shows the state as its plain binary count value (state k reads as k).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dir_dn | input | 1 | Count direction: 0 counts up, 1 counts down |
| cnt_o | output | 2 | Present count, binary |
| hit_o | output | 1 | High when the coming edge moves the count onto 2 |

## Verification
Long runs of up-steps and of down-steps check each direction and pass both wrap points. A run in which the direction alternates every cycle makes the counter rock between two values. This separates a detector that looks at the next count from one that only checks the present count or only one direction. A long stretch of random directions covers every pairing of state and input. Resets applied in the middle of a run, with either direction held and with the count sitting at 1 or at 3, show that the reset wins over counting and that the detect output stays low during reset.

// File: rtl/updn4_pkg.sv
// Package: shared widths, types and constants for the mod-4 up/down counter.
// Assumes: the count width stays 2; the detected value fits in that width.
package updn4_pkg;
    parameter int CNT_W = 2;
    localparam int CNT_MAX = (1 << CNT_W) - 1;

    typedef logic [CNT_W-1:0] cnt_t;

    // Direction encoding on the dir_dn pin
    typedef enum logic {
        DIR_UP = 1'b0,
        DIR_DN = 1'b1
    } dir_e;

    localparam cnt_t DETECT_CNT = cnt_t'(2);
    localparam cnt_t ZERO_CNT   = cnt_t'(0);
    localparam cnt_t STEP_ONE   = cnt_t'(1);
endpackage

// File: rtl/updn4_next.sv
// Module: next-state logic. Forms the next count from the present count and
// the direction; wraps modulo 2**CNT_W in both directions.
// Assumes: purely combinational; the register stage applies reset.
module updn4_next
    import updn4_pkg::*;
(
    input  cnt_t cur_i,
    input  logic dir_i,
    output cnt_t nxt_o
);
    // Step up or down; the natural width truncation gives the wrap
    always_comb begin
        if (dir_e'(dir_i) == DIR_DN) begin
            nxt_o = cur_i - STEP_ONE;
        end else begin
            nxt_o = cur_i + STEP_ONE;
        end
    end
endmodule

// File: rtl/updn4_state_reg.sv
// Module: state register, one D flip-flop per count bit.
// Assumes: synchronous active-low reset that clears every bit.
module updn4_state_reg
    import updn4_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  cnt_t d_i,
    output cnt_t q_o
);
    for (genvar b = 0; b < CNT_W; b++) begin : g_bit
        // Capture one next-state bit per edge, clear on reset
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q_o[b] <= 1'b0;
            end else begin
                q_o[b] <= d_i[b];
            end
        end
    end
endmodule

// File: rtl/updn4_detect.sv
// Module: Mealy detector. Flags the transition that will land on DETECT_CNT.
// Assumes: nxt_i is the next count derived from the present count and the
// direction; output is gated low during reset.
module updn4_detect
    import updn4_pkg::*;
(
    input  logic rst_n,
    input  cnt_t nxt_i,
    output logic hit_o
);
    // Raise the flag when the coming edge reaches the detected count
    always_comb begin
        hit_o = rst_n && (nxt_i == DETECT_CNT);
    end
endmodule

// File: rtl/updn4_cnt_det.sv
// Module: top of the mod-4 up/down counter with count-two detection.
// Assumes: dir_dn is synchronous to clk; rst_n is sampled on the rising edge.
module updn4_cnt_det
    import updn4_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 dir_dn,
    output logic [CNT_W-1:0]     cnt_o,
    output logic                 hit_o
);
    cnt_t cur_q;
    cnt_t nxt_c;
    logic rst_lo_q;

    updn4_next u_next (
        .cur_i (cur_q),
        .dir_i (dir_dn),
        .nxt_o (nxt_c)
    );

    updn4_state_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (nxt_c),
        .q_o   (cur_q)
    );

    updn4_detect u_det (
        .rst_n (rst_n),
        .nxt_i (nxt_c),
        .hit_o (hit_o)
    );

    // Expose the state as its binary count
    assign cnt_o = cur_q;

    // Remember whether reset was low at the previous edge (checker use)
    always_ff @(posedge clk) begin
        rst_lo_q <= !rst_n;
    end

    // R1: the count reads 0 after any edge with reset low
    always_ff @(posedge clk) begin
        if (rst_lo_q) begin
            rst_clear_chk: assert (cur_q == ZERO_CNT)
                else $error("count not cleared by reset");
        end
    end

    // R1: no detect while reset is held
    always_comb begin
        if (!rst_n) begin
            hit_quiet_rst_chk: assert (!hit_o)
                else $error("detect high during reset");
        end
    end

    // R2
    step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_dn == DIR_UP) |=> (cur_q == cnt_t'($past(cur_q) + STEP_ONE)))
        else $error("up step wrong");

    // R3
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_dn == DIR_DN) |=> (cur_q == cnt_t'($past(cur_q) - STEP_ONE)))
        else $error("down step wrong");

    // R8
    hit_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |=> (cur_q == DETECT_CNT))
        else $error("detect not followed by count two");

    // R7
    no_hit_no_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_o |=> (cur_q != DETECT_CNT))
        else $error("count two reached without detect");
endmodule

// File: tb/updn4_cnt_det_tb_top.sv
module updn4_cnt_det_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dir_dn = 1'b0;
    logic [1:0] cnt_o;
    logic       hit_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [1:0] cnt;
        logic       hit;
        bit         chk_cnt;
        string      cnt_tag;
        string      hit_tag;
    } item_t;

    item_t q[$];

    logic [1:0] m_cnt;
    bit         m_known = 1'b0;
    string      prev_tag = "R1";

    always #4 clk = ~clk;   // 125 MHz

    updn4_cnt_det dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .dir_dn (dir_dn),
        .cnt_o  (cnt_o),
        .hit_o  (hit_o)
    );

    // Driver: apply one cycle of stimulus and push the expected outputs
    task automatic step(input logic r, input logic d);
        item_t it;
        @(negedge clk);
        rst_n  = r;
        dir_dn = d;
        #1;
        it.cnt     = m_cnt;
        it.chk_cnt = m_known;
        it.cnt_tag = {prev_tag, "/R9"};
        if (!r) begin
            it.hit     = 1'b0;
            it.hit_tag = "R1";
            m_cnt      = 2'd0;
            m_known    = 1'b1;
            prev_tag   = "R1";
        end else begin
            it.hit     = ((m_cnt == 2'd1) && !d) || ((m_cnt == 2'd3) && d);
            it.hit_tag = it.hit ? "R6/R8" : "R7";
            if (!d) prev_tag = (m_cnt == 2'd3) ? "R4" : "R2";
            else    prev_tag = (m_cnt == 2'd0) ? "R5" : "R3";
            m_cnt = d ? m_cnt - 2'd1 : m_cnt + 2'd1;
        end
        q.push_back(it);
    endtask

    // Monitor: pop expected items and compare with the outputs
    initial begin
        item_t it;
        forever begin
            wait (q.size() > 0);
            it = q.pop_front();
            if (it.chk_cnt) begin
                n_chk++;
                if (cnt_o !== it.cnt) begin
                    n_fail++;
                    $display("FAIL %s: cnt_o=%0d expected %0d", it.cnt_tag, cnt_o, it.cnt);
                end
            end
            n_chk++;
            if (hit_o !== it.hit) begin
                n_fail++;
                $display("FAIL %s: hit_o=%0b expected %0b (cnt=%0d dir=%0b)",
                         it.hit_tag, hit_o, it.hit, cnt_o, dir_dn);
            end
        end
    end

    // Watchdog
    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        step(1'b0, 1'b0);
        step(1'b0, 1'b1);
        // R2, R4: counting up through the wrap
        for (int i = 0; i < 10; i++) step(1'b1, 1'b0);
        // R3, R5: counting down through the wrap
        for (int i = 0; i < 10; i++) step(1'b1, 1'b1);
        // R6, R7: alternate direction around several counts
        for (int i = 0; i < 12; i++) step(1'b1, i[0]);
        step(1'b1, 1'b0); step(1'b1, 1'b0);
        for (int i = 0; i < 8; i++) step(1'b1, ~i[0]);
        // R1: reset mid-run from count 1 while counting up (would hit)
        step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        // R1: reset from count 3 while counting down (would hit)
        step(1'b1, 1'b1);
        step(1'b0, 1'b1);
        step(1'b1, 1'b1);
        // R2..R8: random directions
        for (int i = 0; i < 400; i++) step(1'b1, 1'($urandom_range(0, 1)));
        // Random with occasional reset
        for (int i = 0; i < 200; i++) step(($urandom_range(0, 15) != 0), 1'($urandom_range(0, 1)));
        step(1'b1, 1'b0);
        @(negedge clk);
        wait (q.size() == 0);
        #1;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule